// File: doc/BRIEF.md
# Programmable Chip-Select Port Pin

This block controls a single pin of a small multipurpose port. Software picks one of four roles for the pin: an ordinary output bit driven from a data latch, or a chip select raised from the external bus address and qualified by the read strobe, the write strobe, or either strobe. Each pin holds its own 16-bit base address, loaded as two bytes. It also holds a compare-length code that lets the comparator ignore up to three low address bits, so that one select covers a block of 2, 4 or 8 addresses. A polarity bit sets whether the select is active low or active high.

Configuration arrives through a byte-wide register write port. The output pin is combinational from the registered configuration and the live bus address and strobes. The level seen at the pad is always returned on a separate read path, whatever role the pin has.

Top module: `csdec_pin`

## Requirements
- R1: After synchronous reset the base address is 0, the mode register is 0 (data role, full compare, no inversion) and the data latch is 1, so `pad_out` is 1.
- R2: A write with `cfg_we`=1 updates the register named by `cfg_sel` at the clock edge: 0 = base low byte, 1 = base high byte, 2 = mode (bits 1:0 compare length, bits 3:2 role, bit 4 invert), 3 = data latch (bit 0).
- R3: In the data role (role code 0) `pad_out` equals the data latch, and the bus address and strobes have no effect on it.
- R4: With compare length 0 all 16 address bits must equal the base for a match.
- R5: Compare length codes 1, 2 and 3 ignore the lowest 1, 2 and 3 address bits respectively.
- R6: Role code 1 (read select) is active only while `bus_rd` is 1 and the address matches.
- R7: Role code 2 (write select) is active only while `bus_wr` is 1 and the address matches.
- R8: Role code 3 (read-or-write select) is active while the address matches and either strobe is 1.
- R9: With invert 0 an active select drives `pad_out` to 0 and an inactive one to 1; invert 1 swaps both levels. Invert has no effect in the data role.
- R10: `pad_rdata` always equals `pad_in`.
- R11: A configuration write affects `pad_out` only from the cycle after its clock edge; during the write cycle the output follows the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Register select for the write |
| cfg_wdata | input | 8 | Write data byte |
| bus_addr | input | 16 | Current external bus address |
| bus_rd | input | 1 | Bus read strobe, active high |
| bus_wr | input | 1 | Bus write strobe, active high |
| pad_in | input | 1 | Level sensed at the pad |
| pad_out | output | 1 | Level driven to the pad |
| pad_rdata | output | 1 | Pad level returned on the read path |

## Verification
A configuration write and a live bus strobe can fall in the same cycle. In that case the select must still be decoded from the old base and mode, and the new settings apply from the next cycle. The bench provokes this by writing the base bytes and the mode while holding a read strobe on an address that matches only one of the two settings. A per-cycle reference model updates its registers only at the edge, and it judges the outcome in that cycle and the next.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int BYTE_W = 8;
    localparam int MAX_IGNORE = 3;

    typedef enum logic [1:0] {
        FN_DATA = 2'd0,
        FN_RDCS = 2'd1,
        FN_WRCS = 2'd2,
        FN_RWCS = 2'd3
    } fn_e;

    typedef enum logic [1:0] {
        SEL_BASE_LO = 2'd0,
        SEL_BASE_HI = 2'd1,
        SEL_MODE    = 2'd2,
        SEL_LATCH   = 2'd3
    } sel_e;

    typedef struct packed {
        logic       inv;
        fn_e        fn;
        logic [1:0] len;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic strobe_ok(fn_e fn, logic rd, logic wr);
        case (fn)
            FN_RDCS: return rd;
            FN_WRCS: return wr;
            FN_RWCS: return rd | wr;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int ADDR_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_q,
    output mode_t             mode_q,
    output logic              latch_q
);

    logic unused_wbits;
    assign unused_wbits = ^cfg_wdata[BYTE_W-1:MODE_W];

    for (genvar b = 0; b < NBYTES; b++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst)
                base_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (cfg_we && cfg_sel == 2'(b))
                base_q[b*BYTE_W +: BYTE_W] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            latch_q <= 1'b1;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_MODE)  mode_q  <= mode_t'(cfg_wdata[MODE_W-1:0]);
            if (cfg_sel == SEL_LATCH) latch_q <= cfg_wdata[0];
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (base_q == '0 && mode_q == '0 && latch_q));

    // R2
    mode_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_MODE) |=> (mode_q == mode_t'($past(cfg_wdata[MODE_W-1:0]))));

    // R2
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(base_q));

endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        len,
    output logic              hit
);

    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        if (i < MAX_IGNORE) begin : g_maskable
            assign bit_ok[i] = (addr[i] == base[i]) || (int'(len) > i);
        end else begin : g_fixed
            assign bit_ok[i] = (addr[i] == base[i]);
        end
    end

    assign hit = &bit_ok;

    // R4
    exact_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == base) |-> hit);

    // R5
    high_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:MAX_IGNORE] != base[ADDR_W-1:MAX_IGNORE]) |-> !hit);

endmodule

// File: rtl/csdec_outmux.sv
module csdec_outmux
    import csdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    input  logic  latch,
    input  logic  hit,
    input  logic  rd,
    input  logic  wr,
    output logic  pin
);

    logic sel_active;

    always_comb begin
        sel_active = hit && strobe_ok(mode.fn, rd, wr);
        if (mode.fn == FN_DATA)
            pin = latch;
        else
            pin = sel_active ? mode.inv : ~mode.inv;
    end

    // R3
    data_role_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.fn == FN_DATA) |-> (pin == latch));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.fn != FN_DATA && !rd && !wr) |-> (pin == ~mode.inv));

    // R6
    rd_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.fn == FN_RDCS && !rd) |-> (pin == ~mode.inv));

    // R7
    wr_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode.fn == FN_WRCS && !wr) |-> (pin == ~mode.inv));

endmodule

// File: rtl/csdec_pin.sv
module csdec_pin
    import csdec_pkg::*;
#(
    parameter int NBYTES = 2,
    localparam int ADDR_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_rdata
);

    logic [ADDR_W-1:0] base_q;
    mode_t             mode_q;
    logic              latch_q;
    logic              hit;

    csdec_regs #(.NBYTES(NBYTES)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .mode_q(mode_q), .latch_q(latch_q)
    );

    csdec_match #(.ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst(rst), .addr(bus_addr), .base(base_q),
        .len(mode_q.len), .hit(hit)
    );

    csdec_outmux u_outmux (
        .clk(clk), .rst(rst), .mode(mode_q), .latch(latch_q), .hit(hit),
        .rd(bus_rd), .wr(bus_wr), .pin(pad_out)
    );

    assign pad_rdata = pad_in;

    // R10
    readback_chk: assert property (@(posedge clk) disable iff (rst)
        pad_rdata == pad_in);

endmodule

// File: tb/csdec_pin_bench.sv
module csdec_pin_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        pad_in = 1'b0;
    logic        pad_out;
    logic        pad_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference state
    int m_base = 0;
    int m_len = 0;
    int m_fn = 0;
    int m_inv = 0;
    int m_latch = 1;

    always #5 clk = ~clk;

    csdec_pin u_csdec_pin (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .pad_in(pad_in), .pad_out(pad_out), .pad_rdata(pad_rdata)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_base <= 0; m_len <= 0; m_fn <= 0; m_inv <= 0; m_latch <= 1;
        end else if (cfg_we) begin
            case (cfg_sel)
                2'd0: m_base <= (m_base & 32'hFF00) | int'(cfg_wdata);
                2'd1: m_base <= (m_base & 32'h00FF) | (int'(cfg_wdata) << 8);
                2'd2: begin
                    m_len <= cfg_wdata & 3;
                    m_fn  <= (cfg_wdata >> 2) & 3;
                    m_inv <= (cfg_wdata >> 4) & 1;
                end
                default: m_latch <= cfg_wdata & 1;
            endcase
        end
    end

    function automatic int expect_pin();
        int sh;
        bit hit;
        bit strobe;
        if (m_fn == 0) return m_latch;
        sh = m_len;
        hit = ((int'(bus_addr) >> sh) == (m_base >> sh));
        strobe = (m_fn == 1) ? bus_rd : (m_fn == 2) ? bus_wr : (bus_rd | bus_wr);
        return (hit && strobe) ? m_inv : 1 - m_inv;
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            int e;
            e = expect_pin();
            checks++;
            if (int'(pad_out) != e) begin
                fails++;
                $display("FAIL %s pad_out: actual %0d expected %0d (addr %h rd %0b wr %0b)",
                         tag, pad_out, e, bus_addr, bus_rd, bus_wr);
            end
            checks++;
            if (pad_rdata !== pad_in) begin
                fails++;
                $display("FAIL R10 pad_rdata: actual %0b expected %0b", pad_rdata, pad_in);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        pad_in = ~pad_in;
    endtask

    task automatic wr_cfg(input logic [1:0] s, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [15:0] a, input logic r, input logic w);
        bus_addr = a; bus_rd = r; bus_wr = w;
        step();
    endtask

    function automatic logic [7:0] mode_byte(int len, int fn, int inv);
        return 8'((inv << 4) | (fn << 2) | len);
    endfunction

    initial begin
        repeat (3) step();
        rst = 1'b0;
        tag = "R1";
        drive(16'h0000, 0, 0);
        drive(16'h0000, 1, 1);

        // R3: data role ignores the bus
        tag = "R3";
        wr_cfg(2'd3, 8'h00);
        for (int k = 0; k < 4; k++) drive(16'(k * 16'h1111), k[0], k[1]);
        wr_cfg(2'd3, 8'hFF);
        drive(16'h0000, 1, 0);
        // R9: invert bit has no effect in the data role
        tag = "R9";
        wr_cfg(2'd2, mode_byte(0, 0, 1));
        drive(16'h0000, 1, 1);

        // R2 + R11: base and mode writes coinciding with a read strobe
        tag = "R11";
        bus_addr = 16'h1234; bus_rd = 1'b1;
        wr_cfg(2'd0, 8'h34);
        wr_cfg(2'd1, 8'h12);
        wr_cfg(2'd2, mode_byte(0, 1, 0));
        tag = "R2";
        drive(16'h1234, 1, 0);

        // R4: full compare
        tag = "R4";
        drive(16'h1235, 1, 0);
        drive(16'h1334, 1, 0);
        drive(16'h9234, 1, 0);
        drive(16'h1234, 1, 0);

        // R6 / R7 / R8 strobe qualification under each invert setting
        for (int inv = 0; inv < 2; inv++) begin
            for (int fn = 1; fn < 4; fn++) begin
                tag = (fn == 1) ? "R6" : (fn == 2) ? "R7" : "R8";
                wr_cfg(2'd2, mode_byte(0, fn, inv));
                for (int s = 0; s < 4; s++) begin
                    drive(16'h1234, s[0], s[1]);
                    drive(16'h1230, s[0], s[1]);
                end
            end
        end

        // R9: active-high select
        tag = "R9";
        wr_cfg(2'd2, mode_byte(0, 3, 1));
        drive(16'h1234, 0, 1);
        drive(16'h1234, 0, 0);

        // R5: reduced compare lengths
        tag = "R5";
        for (int len = 0; len < 4; len++) begin
            wr_cfg(2'd2, mode_byte(len, 1, 0));
            for (int a = 16'h1228; a < 16'h1240; a++) drive(16'(a), 1, 0);
        end
        wr_cfg(2'd0, 8'hFF);
        wr_cfg(2'd1, 8'hFF);
        wr_cfg(2'd2, mode_byte(3, 3, 0));
        for (int a = 16'hFFF0; a <= 16'hFFFF; a++) drive(16'(a), 0, 1);
        drive(16'h7FFF, 1, 1);

        // R11: mode change back to data role during a strobe
        tag = "R11";
        bus_addr = 16'hFFFF; bus_rd = 1'b1;
        wr_cfg(2'd2, mode_byte(0, 0, 0));
        tag = "R3";
        drive(16'hFFFF, 1, 0);

        // R1: reset restores defaults
        rst = 1'b1;
        step();
        rst = 1'b0;
        tag = "R1";
        drive(16'h0000, 1, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule